// File: doc/BRIEF.md
# External Agent Bus Takeover Bridge

This block lets an external bus master, for example a coprocessor, borrow the multiplexed address/data bus of a host CPU. When the agent asks for the bus, the bridge raises its own request toward the CPU. It passes a grant down to the agent only after the CPU reports that it has released the bus. While the agent owns the bus, the bridge takes over several CPU-side duties. It drives the CPU control lines to their idle levels and lets the write line follow the agent's direction. It pulses the address latch enable and keeps a copy of the agent's word address. It returns an address acknowledge one clock later, so the agent keeps driving the address until the system has latched it. It also sequences the output-enable and direction controls of the agent-side transceiver.

In the other direction, when the CPU selects the agent as a slave, the bridge asserts a chip select to the agent and then an address strobe one clock later. All handshake pins are plain, single-bit, active-low control pins except the address latch enable, which is active high. No data stream passes through the block, so it has no valid/ready interface. Every output is decoded from a registered state, and all inputs are sampled on the rising clock edge.

Top module: `xbus_bridge`

## Requirements
- R1: While reset is low, and on the clock after any reset, every active-low output is high, the address latch enable is low, the control-drive flag is low, and the sequencer is idle.
- R2: An agent request sampled low in idle, while the CPU grant is high and no slave select is pending, drives the CPU bus request low after that edge. The agent grant goes low only on the edge after the CPU grant is sampled low; while the CPU grant stays high, the agent grant stays high.
- R3: Once the agent grant is low, it stays low on every cycle in which the agent request is still sampled low.
- R4: An agent address strobe sampled low while the agent is granted raises the address latch enable for exactly one cycle. The address acknowledge goes low for exactly one cycle, starting on the cycle right after that latch enable.
- R5: With the address strobe, the bridge captures bus bits 31:2 as the word address, and bits 3:2 are address bits rather than byte enables. The copy is visible from the latch-enable cycle onward and holds until the next capture.
- R6: The agent output enable is low during the latch-enable cycle, the acknowledge cycle and the data phase. The direction control is low during the latch-enable and acknowledge cycles, and during the data phase of an agent write. It is high in the data phase of an agent read.
- R7: The agent direction input is sampled with the address strobe (1 = write). During the latch-enable cycle, the acknowledge cycle and the data phase, the CPU write line is low for a write and high for a read. The CPU read and burst lines stay high at all times. The data-enable line is low only in the data phase of a read. The control-drive flag is high from grant through the data phase.
- R8: A data beat completes only when the data strobe and the data acknowledge are both sampled low at the same edge. After that edge the output enable rises and the bridge waits, still granted, for the next address strobe. If only one of the two is low, the data phase continues.
- R9: After the agent request is sampled high, the agent grant rises on the next edge and the CPU bus request rises one edge later. No new agent request is accepted until the CPU grant has been sampled high. A request withdrawn before the grant releases the CPU request directly.
- R10: A CPU select sampled high in idle has priority over an agent request. The agent chip select goes low after that edge and the agent address strobe goes low one clock later. Both rise on the edge after the select is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agt_req_n | input | 1 | Agent bus request |
| agt_gnt_n | output | 1 | Agent bus grant |
| agt_as_n | input | 1 | Agent address strobe (master mode) |
| agt_ds_n | input | 1 | Agent data strobe |
| agt_dtack_n | input | 1 | Data acknowledge for the current beat |
| agt_wr | input | 1 | Agent transfer direction, 1 = write |
| agt_ad | input | 30 | Bus bits 31:2 during the address phase |
| lat_addr | output | 30 | Captured agent word address |
| agt_aack_n | output | 1 | Address acknowledge to the agent |
| agt_oe_n | output | 1 | Agent transceiver output enable |
| agt_dir_n | output | 1 | Agent transceiver direction, low = agent drives |
| agt_cs_n | output | 1 | Chip select for a CPU access to the agent |
| agt_sas_n | output | 1 | Address strobe toward the agent as slave |
| cpu_sel | input | 1 | CPU is accessing the agent |
| cpu_breq_n | output | 1 | Bus request to the CPU |
| cpu_bgnt_n | input | 1 | Bus grant from the CPU |
| cpu_ale | output | 1 | Address latch enable, active high |
| cpu_rd_n | output | 1 | CPU read line during takeover |
| cpu_wr_n | output | 1 | CPU write line during takeover |
| cpu_burst_n | output | 1 | CPU burst line during takeover |
| cpu_dataen_n | output | 1 | Data enable during takeover reads |
| cpu_ctl_en | output | 1 | High while the bridge drives the CPU control lines |

## Verification
Every result of this block appears on the first clock edge after the stimulus that causes it. The only exceptions are the chained outcomes that follow from it: the address acknowledge one edge after the latch enable, the CPU request release one edge after the grant drop, and the slave address strobe one edge after the chip select. The bench changes inputs two nanoseconds after a rising edge and queues the full output vector it expects after the next edge. A monitor compares that vector one nanosecond after the edge. Each multi-edge outcome is therefore checked one queued step at a time, so a result that comes one cycle early or late shows up as a mismatch. The captured address is read in the latch-enable cycle and again later to confirm that it holds.

// File: rtl/xbus_bridge_pkg.sv
package xbus_bridge_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_GNT, ST_ALE, ST_AACK, ST_DATA,
    ST_DROP, ST_REL, ST_WAITNG, ST_SLCS, ST_SLAS
  } xb_state_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      agt_req_n,
  input  logic      agt_as_n,
  input  logic      agt_ds_n,
  input  logic      agt_dtack_n,
  input  logic      cpu_bgnt_n,
  input  logic      cpu_sel,
  output xb_state_e state_q
);
  xb_state_e nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_sel) nxt = ST_SLCS;
                 else if (!agt_req_n && cpu_bgnt_n) nxt = ST_REQ;
      ST_REQ:    if (agt_req_n) nxt = ST_REL;
                 else if (!cpu_bgnt_n) nxt = ST_GNT;
      ST_GNT:    if (agt_req_n) nxt = ST_DROP;
                 else if (!agt_as_n) nxt = ST_ALE;
      ST_ALE:    nxt = ST_AACK;
      ST_AACK:   nxt = ST_DATA;
      ST_DATA:   if (agt_req_n) nxt = ST_DROP;
                 else if (!agt_ds_n && !agt_dtack_n) nxt = ST_GNT;
      ST_DROP:   nxt = ST_REL;
      ST_REL:    nxt = ST_WAITNG;
      ST_WAITNG: if (cpu_bgnt_n) nxt = ST_IDLE;
      ST_SLCS:   nxt = ST_SLAS;
      ST_SLAS:   if (!cpu_sel) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt;
  end

  // R2: grant only after the CPU released the bus
  p_gnt_after_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && cpu_bgnt_n) |=> state_q != ST_GNT);
  // R9: no new request before the CPU grant is seen high
  p_wait_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAITNG && !cpu_bgnt_n) |=> state_q == ST_WAITNG);
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int AD_W     = 32,
  parameter int ADDR_LSB = 2,
  localparam int WA_W    = AD_W - ADDR_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [WA_W-1:0] ad_in,
  input  logic            wr_in,
  output logic [WA_W-1:0] addr_q,
  output logic            wr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (take) begin
      addr_q <= ad_in;
      wr_q   <= wr_in;
    end
  end

  // R5: the copy only changes on a capture
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(addr_q));
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  xb_state_e state_q,
  input  logic      wr_q,
  output logic      agt_gnt_n,
  output logic      cpu_breq_n,
  output logic      cpu_ale,
  output logic      agt_aack_n,
  output logic      agt_oe_n,
  output logic      agt_dir_n,
  output logic      cpu_rd_n,
  output logic      cpu_wr_n,
  output logic      cpu_burst_n,
  output logic      cpu_dataen_n,
  output logic      agt_cs_n,
  output logic      agt_sas_n,
  output logic      cpu_ctl_en
);
  logic granted, xfer, owning;

  always_comb begin
    granted = state_q inside {ST_GNT, ST_ALE, ST_AACK, ST_DATA};
    xfer    = state_q inside {ST_ALE, ST_AACK, ST_DATA};
    owning  = granted || state_q == ST_REQ || state_q == ST_DROP;

    agt_gnt_n    = !granted;
    cpu_breq_n   = !owning;
    cpu_ale      = state_q == ST_ALE;
    agt_aack_n   = state_q != ST_AACK;
    agt_oe_n     = !xfer;
    agt_dir_n    = !(state_q == ST_ALE || state_q == ST_AACK ||
                     (state_q == ST_DATA && wr_q));
    cpu_rd_n     = 1'b1;
    cpu_burst_n  = 1'b1;
    cpu_wr_n     = !(xfer && wr_q);
    cpu_dataen_n = !(state_q == ST_DATA && !wr_q);
    agt_cs_n     = !(state_q == ST_SLCS || state_q == ST_SLAS);
    agt_sas_n    = state_q != ST_SLAS;
    cpu_ctl_en   = granted;
  end

  // R4: acknowledge exactly one clock after the latch enable
  p_aack_follows_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ale |=> (!agt_aack_n && !cpu_ale));
  p_aack_needs_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(agt_aack_n) |-> $past(cpu_ale));
  // R6: agent never drives with its transceiver disabled
  p_dir_implies_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !agt_dir_n |-> !agt_oe_n);
  // R10: slave strobe only after chip select
  p_sas_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(agt_sas_n) |-> $past(!agt_cs_n));
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_bridge_pkg::*;
#(
  parameter int AD_W     = 32,
  parameter int ADDR_LSB = 2,
  localparam int WA_W    = AD_W - ADDR_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            agt_req_n,
  output logic            agt_gnt_n,
  input  logic            agt_as_n,
  input  logic            agt_ds_n,
  input  logic            agt_dtack_n,
  input  logic            agt_wr,
  input  logic [WA_W-1:0] agt_ad,
  output logic [WA_W-1:0] lat_addr,
  output logic            agt_aack_n,
  output logic            agt_oe_n,
  output logic            agt_dir_n,
  output logic            agt_cs_n,
  output logic            agt_sas_n,
  input  logic            cpu_sel,
  output logic            cpu_breq_n,
  input  logic            cpu_bgnt_n,
  output logic            cpu_ale,
  output logic            cpu_rd_n,
  output logic            cpu_wr_n,
  output logic            cpu_burst_n,
  output logic            cpu_dataen_n,
  output logic            cpu_ctl_en
);
  xb_state_e state_q;
  logic      wr_q;
  logic      take;

  assign take = (state_q == ST_GNT) && !agt_req_n && !agt_as_n;

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .agt_req_n(agt_req_n), .agt_as_n(agt_as_n),
    .agt_ds_n(agt_ds_n), .agt_dtack_n(agt_dtack_n), .cpu_bgnt_n(cpu_bgnt_n),
    .cpu_sel(cpu_sel), .state_q(state_q)
  );

  xbus_capture #(.AD_W(AD_W), .ADDR_LSB(ADDR_LSB)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .ad_in(agt_ad), .wr_in(agt_wr),
    .addr_q(lat_addr), .wr_q(wr_q)
  );

  xbus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .wr_q(wr_q),
    .agt_gnt_n(agt_gnt_n), .cpu_breq_n(cpu_breq_n), .cpu_ale(cpu_ale),
    .agt_aack_n(agt_aack_n), .agt_oe_n(agt_oe_n), .agt_dir_n(agt_dir_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_burst_n(cpu_burst_n),
    .cpu_dataen_n(cpu_dataen_n), .agt_cs_n(agt_cs_n), .agt_sas_n(agt_sas_n),
    .cpu_ctl_en(cpu_ctl_en)
  );

  // R3: grant held while the request stays low
  p_grant_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!agt_gnt_n && !agt_req_n) |=> !agt_gnt_n);
  // R2: the agent is never granted without the CPU request active
  p_gnt_under_breq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !agt_gnt_n |-> !cpu_breq_n);
  // R9: grant drops before the CPU request is released
  p_release_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_breq_n) |-> $past(agt_gnt_n));
  // R7: read and burst stay idle
  p_rd_burst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_n && cpu_burst_n);
endmodule

// File: tb/xbus_bridge_test.sv
`timescale 1ns/1ps
module xbus_bridge_test;
  localparam int WA_W = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic agt_req_n = 1'b1, agt_as_n = 1'b1, agt_ds_n = 1'b1, agt_dtack_n = 1'b1;
  logic agt_wr = 1'b0, cpu_sel = 1'b0, cpu_bgnt_n = 1'b1;
  logic [WA_W-1:0] agt_ad = '0;
  logic [WA_W-1:0] lat_addr;
  logic agt_gnt_n, agt_aack_n, agt_oe_n, agt_dir_n, agt_cs_n, agt_sas_n;
  logic cpu_breq_n, cpu_ale, cpu_rd_n, cpu_wr_n, cpu_burst_n, cpu_dataen_n, cpu_ctl_en;

  int checks = 0;
  int fails  = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  xbus_bridge uut (
    .clk(clk), .rst_n(rst_n), .agt_req_n(agt_req_n), .agt_gnt_n(agt_gnt_n),
    .agt_as_n(agt_as_n), .agt_ds_n(agt_ds_n), .agt_dtack_n(agt_dtack_n),
    .agt_wr(agt_wr), .agt_ad(agt_ad), .lat_addr(lat_addr),
    .agt_aack_n(agt_aack_n), .agt_oe_n(agt_oe_n), .agt_dir_n(agt_dir_n),
    .agt_cs_n(agt_cs_n), .agt_sas_n(agt_sas_n), .cpu_sel(cpu_sel),
    .cpu_breq_n(cpu_breq_n), .cpu_bgnt_n(cpu_bgnt_n), .cpu_ale(cpu_ale),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_burst_n(cpu_burst_n),
    .cpu_dataen_n(cpu_dataen_n), .cpu_ctl_en(cpu_ctl_en)
  );

  // {gnt,breq,ale,aack,oe,dir,rd,wr,burst,den,cs,sas,ctl_en}; rd and burst always high
  function automatic logic [12:0] mk(logic g, logic b, logic a, logic k, logic o,
                                     logic d, logic w, logic e, logic c, logic s, logic n);
    return {g, b, a, k, o, d, 1'b1, w, 1'b1, e, c, s, n};
  endfunction

  localparam logic [12:0] V_IDLE  = 13'b1101111111110;
  localparam logic [12:0] V_REQ   = 13'b1001111111110;
  localparam logic [12:0] V_GNT   = 13'b0001111111111;
  localparam logic [12:0] V_SLCS  = 13'b1101111111010;
  localparam logic [12:0] V_SLAS  = 13'b1101111111000;

  // driver: queue what the outputs must be after the next edge, then step
  task automatic cyc(input logic [12:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
    #2;
  endtask

  task automatic chk_addr(input logic [WA_W-1:0] e, input string t);
    checks++;
    if (lat_addr !== e) begin
      fails++;
      $display("FAIL %s lat_addr actual=%h expected=%h", t, lat_addr, e);
    end
  endtask

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [12:0] act;
      logic [12:0] e;
      string t;
      act = {agt_gnt_n, cpu_breq_n, cpu_ale, agt_aack_n, agt_oe_n, agt_dir_n,
             cpu_rd_n, cpu_wr_n, cpu_burst_n, cpu_dataen_n, agt_cs_n, agt_sas_n, cpu_ctl_en};
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s outputs actual=%b expected=%b", t, act, e);
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(V_IDLE, "R1 reset");
    cyc(V_IDLE, "R1 reset");
    chk_addr('0, "R1 addr reset");
    rst_n = 1'b1;
    cyc(V_IDLE, "R1 after reset");

    // R2 request chaining
    agt_req_n = 1'b0;
    cyc(V_REQ, "R2 cpu request");
    cyc(V_REQ, "R2 no grant while cpu grant high");
    cpu_bgnt_n = 1'b0;
    cyc(V_GNT, "R2 grant after cpu grant");
    cyc(V_GNT, "R3 grant held");

    // write beat
    agt_as_n = 1'b0; agt_wr = 1'b1; agt_ad = 30'h2AF348CF;
    cyc(mk(0,0,1,1,0,0,0,1,1,1,1), "R4 ale write");
    chk_addr(30'h2AF348CF, "R5 capture write");
    agt_as_n = 1'b1; agt_ad = '0;
    cyc(mk(0,0,0,0,0,0,0,1,1,1,1), "R4 aack");
    cyc(mk(0,0,0,1,0,0,0,1,1,1,1), "R6 write data phase");
    chk_addr(30'h2AF348CF, "R5 hold");
    agt_ds_n = 1'b0;
    cyc(mk(0,0,0,1,0,0,0,1,1,1,1), "R8 strobe only");
    agt_dtack_n = 1'b0;
    cyc(V_GNT, "R8 beat done");
    agt_ds_n = 1'b1; agt_dtack_n = 1'b1;

    // read beat, bits 3:2 = 2'b10
    agt_as_n = 1'b0; agt_wr = 1'b0; agt_ad = 30'h000003C2;
    cyc(mk(0,0,1,1,0,0,1,1,1,1,1), "R7 ale read");
    chk_addr(30'h000003C2, "R5 capture bits 3:2");
    agt_as_n = 1'b1;
    cyc(mk(0,0,0,0,0,0,1,1,1,1,1), "R4 aack read");
    cyc(mk(0,0,0,1,0,1,1,0,1,1,1), "R6 R7 read data phase");
    agt_dtack_n = 1'b0;
    cyc(mk(0,0,0,1,0,1,1,0,1,1,1), "R8 ack only");
    agt_ds_n = 1'b0;
    cyc(V_GNT, "R8 read beat done");
    agt_ds_n = 1'b1; agt_dtack_n = 1'b1;
    cyc(V_GNT, "R3 grant held idle");

    // R9 release
    agt_req_n = 1'b1;
    cyc(V_REQ, "R9 grant drop");
    cyc(V_IDLE, "R9 cpu request release");
    agt_req_n = 1'b0;
    cyc(V_IDLE, "R9 wait cpu grant");
    cyc(V_IDLE, "R9 wait cpu grant");
    cpu_bgnt_n = 1'b1;
    cyc(V_IDLE, "R9 back to idle");
    cyc(V_REQ, "R9 new request accepted");
    agt_req_n = 1'b1;
    cyc(V_IDLE, "R9 withdrawn request");
    cyc(V_IDLE, "R9 idle");
    cyc(V_IDLE, "R9 idle");

    // R10 slave access, priority over agent request
    cpu_sel = 1'b1; agt_req_n = 1'b0;
    cyc(V_SLCS, "R10 chip select first");
    cyc(V_SLAS, "R10 strobe one clock later");
    cyc(V_SLAS, "R10 strobe held");
    cpu_sel = 1'b0;
    cyc(V_IDLE, "R10 release");
    cyc(V_REQ, "R2 request after slave access");
    cpu_bgnt_n = 1'b0;
    cyc(V_GNT, "R2 granted");

    // R1 reset mid-ownership
    rst_n = 1'b0;
    #1;
    checks++;
    if (agt_gnt_n !== 1'b1 || cpu_breq_n !== 1'b1) begin
      fails++;
      $display("FAIL R1 async reset actual=%b%b expected=11", agt_gnt_n, cpu_breq_n);
    end
    agt_req_n = 1'b1; cpu_bgnt_n = 1'b1;
    cyc(V_IDLE, "R1 in reset");
    rst_n = 1'b1;
    cyc(V_IDLE, "R1 after second reset");
    chk_addr('0, "R1 addr cleared");

    repeat (2) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule